// File: doc/BRIEF.md
# Serial Deserializer with Bit Slip

This block turns a one-bit serial stream into parallel words of `WORD_W` bits. Every rising edge of the bit-rate clock captures one serial bit into a history register. A frame counter in the same clock domain marks the last bit of each word. On that edge the newest `WORD_W` bits go to `data_out` as one word, with the oldest bit at the MSB, and `word_valid` pulses for one cycle.

The word boundary is not fixed. A static frame-phase setting, given in degrees of one bit period, holds the frame counter still for a whole number of bit times after reset. This decides which serial bit becomes the MSB of the first word. At run time a training state machine can raise `slip_req`. Each accepted request holds the frame counter for one extra bit time, which moves the boundary one bit later. After `WORD_W` accepted slips the boundary is back where it started. After each accepted slip, a lockout window ignores further requests until the new alignment has settled.

Top module: `deser_bitslip`

## Requirements
- R1: Each word carries the `WORD_W` serial bits captured on the edges up to and including the edge where `word_valid` rises. The earliest of those bits is at bit `WORD_W-1` and the latest at bit 0. `WORD_W` is a parameter from 2 to 10, with a default of 8.
- R3: Let p = floor(`frame_phase` / 360) mod `WORD_W`. Number the edges from 0, starting at the first edge with `rst_n` high. The frame counter is held on edges 0 to p-1. The first word is therefore bits p to p+`WORD_W`-1, and the part of the setting below 360 has no effect.
- R4: `word_valid` is high for exactly one cycle per word. With no slips, words appear every `WORD_W` cycles. No word appears before `WORD_W` bits have been counted.
- R5: An accepted slip holds the frame counter on the edge where it is accepted, so the next word arrives `WORD_W+1` cycles after the previous one.
- R6: `slip_count` rises by one, modulo `WORD_W`, on each accepted slip. After `WORD_W` slips it reads 0 and the boundary is back at its original alignment.
- R7: After a slip is accepted on edge s, `slip_req` is ignored on edges s+1 to s+2·`WORD_W`. A request on edge s+2·`WORD_W`+1 is accepted.
- R8: `slip_req` is ignored while the phase hold after reset is still running (edges 0 to p-1).
- R9: While `rst_n` is low at a clock edge, the history, frame counter, slip count and lockout are cleared, `data_out` goes to zero and `word_valid` goes low.
- R10: `data_out` holds its value on every cycle without `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data bit |
| frame_phase | input | $clog2(WORD_W*360) | Frame-phase offset in degrees of one bit period, static |
| slip_req | input | 1 | Request to delay the word boundary by one bit |
| data_out | output | WORD_W | Parallel word, earliest bit at the MSB |
| word_valid | output | 1 | One-cycle strobe for a new word |
| slip_count | output | $clog2(WORD_W) | Accepted slips modulo WORD_W |

## Verification
The assertions check the following on every cycle: that `word_valid` is a single-cycle pulse with at least `WORD_W` cycles between pulses; that `slip_count` only ever steps up by one; that slip changes are at least the lockout window apart; that nothing is accepted during the phase hold; and that reset clears the outputs and the word holds between strobes. They do not check which serial bits land in a word, or which edge a boundary falls on after a given phase or slip history. The bench's scenarios show those: a sweep over every phase, single slips, requests held through the lockout, and a full wrap of `WORD_W` slips, all compared against a stream the bench generates itself.

// File: rtl/deser_pkg.sv
// Package: shared constants and helpers for the bit-slip deserializer.
// Assumes phase settings are expressed in degrees of one serial bit period.
package deser_pkg;

    localparam int MAX_WORD_W  = 10;
    localparam int DEG_PER_BIT = 360;

    // Width of the frame-phase setting for a given word width.
    function automatic int phase_width(input int word_w);
        return $clog2(word_w * DEG_PER_BIT);
    endfunction

endpackage

// File: rtl/deser_capture.sv
// Module: deser_capture
// Shifts the serial input into a history register on every rising edge of
// the bit clock. The register keeps the WORD_W-1 most recent bits, with the
// newest bit at index 0. The word stage adds the bit of the current edge.
// Assumes: WORD_W >= 2, synchronous active-low reset.
module deser_capture #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [WORD_W-2:0] hist
);

    localparam int HIST_W = WORD_W - 1;

    // Bit history: shift one serial bit in per clock.
    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= ser_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= {hist[HIST_W-2:0], ser_in};
            end
        end
    endgenerate

endmodule

// File: rtl/deser_slip_ctl.sv
// Module: deser_slip_ctl
// Accepts bit-slip requests. A request is taken when no phase hold is running
// and the lockout window has run out. Each taken request advances the slip
// count modulo WORD_W and starts a lockout of 2*WORD_W cycles.
// Assumes: slip_req is synchronous to clk; phase_busy comes from the framer.
module deser_slip_ctl #(
    parameter int WORD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slip_req,
    input  logic                      phase_busy,
    output logic                      slip_take,
    output logic [$clog2(WORD_W)-1:0] slip_count
);

    localparam int CNT_W   = $clog2(WORD_W);
    localparam int LOCK_N  = 2 * WORD_W;
    localparam int LOCK_W  = $clog2(LOCK_N + 1);

    logic [LOCK_W-1:0] lock_left;

    // Acceptance: a request counts only outside the phase hold and the lockout.
    always_comb begin
        slip_take = slip_req && !phase_busy && (lock_left == '0);
    end

    // Lockout timer: load on an accepted slip, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               lock_left <= '0;
        else if (slip_take)       lock_left <= LOCK_W'(LOCK_N);
        else if (lock_left != '0) lock_left <= lock_left - 1'b1;
    end

    // Slip counter: modulo-WORD_W count of accepted slips.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slip_count <= '0;
        else if (slip_take)
            slip_count <= (slip_count == CNT_W'(WORD_W - 1)) ? '0 : slip_count + 1'b1;
    end

endmodule

// File: rtl/deser_framer.sv
// Module: deser_framer
// Frame counter that marks the last bit of each word. After reset it holds
// for floor(phase/360) mod WORD_W edges, which sets where the MSB lands. It
// also holds for one edge on each accepted slip. It advances on every other
// edge, and raises emit on the advancing edge that completes a word.
// Assumes: frame_phase is static while rst_n is high.
module deser_framer #(
    parameter int WORD_W = 8,
    parameter int DEG_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEG_W-1:0] frame_phase,
    input  logic             slip_take,
    output logic             phase_busy,
    output logic             emit
);

    localparam int CNT_W = $clog2(WORD_W);

    logic [CNT_W-1:0] bit_pos;
    logic [CNT_W-1:0] phase_left;
    logic [CNT_W-1:0] phase_bits;
    logic             advance;

    // Phase conversion: whole bit periods in the setting, modulo the word width.
    always_comb begin
        phase_bits = CNT_W'((frame_phase / DEG_W'(deser_pkg::DEG_PER_BIT)) % DEG_W'(WORD_W));
    end

    // Hold decision: the counter stands still during the phase hold or a slip.
    always_comb begin
        phase_busy = (phase_left != '0);
        advance    = !phase_busy && !slip_take;
        emit       = advance && (bit_pos == CNT_W'(WORD_W - 1));
    end

    // Phase hold: load the offset in reset, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_left <= phase_bits;
        else if (phase_busy) phase_left <= phase_left - 1'b1;
    end

    // Bit position: wraps at WORD_W and only moves on advancing edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_pos <= '0;
        else if (advance)
            bit_pos <= (bit_pos == CNT_W'(WORD_W - 1)) ? '0 : bit_pos + 1'b1;
    end

endmodule

// File: rtl/deser_word_out.sv
// Module: deser_word_out
// Registers a parallel word on each emit: the history bits plus the bit of
// the current edge, with the earliest bit at the MSB. It drives a one-cycle
// valid strobe with the word, and holds the word until the next emit.
// Assumes: emit is never high on two consecutive edges.
module deser_word_out #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic              ser_in,
    input  logic [WORD_W-2:0] hist,
    output logic [WORD_W-1:0] data_out,
    output logic              word_valid
);

    // Word register: load on emit, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_out <= '0;
        else if (emit) data_out <= {hist, ser_in};
    end

    // Valid strobe: high for the cycle after each emitting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) word_valid <= 1'b0;
        else        word_valid <= emit;
    end

endmodule

// File: rtl/deser_bitslip.sv
// Module: deser_bitslip (top)
// Serial-to-parallel converter with a frame-phase offset and run-time bit
// slip. Everything runs on the bit-rate clock: capture, slip control,
// framing and word output.
// Assumes: 2 <= WORD_W <= 10; frame_phase is static outside reset.
module deser_bitslip #(
    parameter int WORD_W = 8,
    parameter int DEG_W  = deser_pkg::phase_width(WORD_W),
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic [DEG_W-1:0]  frame_phase,
    input  logic              slip_req,
    output logic [WORD_W-1:0] data_out,
    output logic              word_valid,
    output logic [CNT_W-1:0]  slip_count
);

    logic [WORD_W-2:0] hist;
    logic              slip_take;
    logic              phase_busy;
    logic              emit;

    // Serial capture stage.
    deser_capture #(.WORD_W(WORD_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .hist   (hist)
    );

    // Slip acceptance and lockout.
    deser_slip_ctl #(.WORD_W(WORD_W)) u_slip (
        .clk        (clk),
        .rst_n      (rst_n),
        .slip_req   (slip_req),
        .phase_busy (phase_busy),
        .slip_take  (slip_take),
        .slip_count (slip_count)
    );

    // Word-boundary framing.
    deser_framer #(.WORD_W(WORD_W), .DEG_W(DEG_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_phase (frame_phase),
        .slip_take   (slip_take),
        .phase_busy  (phase_busy),
        .emit        (emit)
    );

    // Parallel word register and strobe.
    deser_word_out #(.WORD_W(WORD_W)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit       (emit),
        .ser_in     (ser_in),
        .hist       (hist),
        .data_out   (data_out),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/deser_bitslip_checker.sv
// Module: deser_bitslip_checker
// Protocol checks for deser_bitslip, attached with bind. It watches the top
// ports and the framer's phase-hold flag. Lockout and word spacing are
// measured with local counters, not deep $past.
module deser_bitslip_checker #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] data_out,
    input logic              word_valid,
    input logic [CNT_W-1:0]  slip_count,
    input logic              phase_busy
);

    localparam int GAP_W  = $clog2(WORD_W + 1);
    localparam int LOCK_N = 2 * WORD_W;
    localparam int SINCE_W = $clog2(LOCK_N + 1);

    logic               armed = 1'b0;
    logic [GAP_W-1:0]   gap;
    logic               seen_word;
    logic [SINCE_W-1:0] since_slip;
    logic [CNT_W-1:0]   prev_count;

    // Arm flag: blocks the first edge, which has no valid past.
    always_ff @(posedge clk) armed <= 1'b1;

    // R9: the cycle after a reset edge shows cleared outputs.
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!armed)
        !$past(rst_n) |-> (data_out == '0 && !word_valid && slip_count == '0));

    // R4: the valid strobe lasts a single cycle.
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R10: the word holds between strobes.
    p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !word_valid) |-> data_out == $past(data_out));

    // R6: the slip count only steps up by one, modulo WORD_W.
    p_slip_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && slip_count != $past(slip_count)) |->
            slip_count == (($past(slip_count) == CNT_W'(WORD_W - 1)) ? '0 : $past(slip_count) + 1'b1));

    // R8: no slip is accepted during the phase hold.
    p_phase_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_busy |=> $stable(slip_count));

    // R4 spacing and R7 lockout, measured with local counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap        <= '0;
            seen_word  <= 1'b0;
            since_slip <= SINCE_W'(LOCK_N);
            prev_count <= '0;
        end else begin
            if (word_valid) begin
                p_gap_r4: assert (!seen_word || gap >= GAP_W'(WORD_W - 1));
                gap       <= '0;
                seen_word <= 1'b1;
            end else if (gap != GAP_W'(WORD_W)) begin
                gap <= gap + 1'b1;
            end
            if (slip_count != prev_count) begin
                p_slip_lock_r7: assert (since_slip >= SINCE_W'(LOCK_N));
                since_slip <= '0;
            end else if (since_slip != SINCE_W'(LOCK_N)) begin
                since_slip <= since_slip + 1'b1;
            end
            prev_count <= slip_count;
        end
    end

endmodule

bind deser_bitslip deser_bitslip_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_out   (data_out),
    .word_valid (word_valid),
    .slip_count (slip_count),
    .phase_busy (phase_busy)
);

// File: tb/deser_bitslip_test.sv
// Bench for deser_bitslip at WORD_W = 8. It sweeps every frame phase, then
// runs single slips, requests held through the lockout, a full wrap of slips,
// and a slip during the phase hold. Expected words come from a stream the
// bench generates itself.
module deser_bitslip_test;

    localparam int W     = 8;
    localparam int DEG_W = $clog2(W * 360);
    localparam int CW    = $clog2(W);
    localparam int NBITS = 2048;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ser_in = 1'b0;
    logic [DEG_W-1:0] frame_phase = '0;
    logic             slip_req = 1'b0;
    logic [W-1:0]     data_out;
    logic             word_valid;
    logic [CW-1:0]    slip_count;

    always #10 clk = ~clk;

    deser_bitslip #(.WORD_W(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .frame_phase (frame_phase),
        .slip_req    (slip_req),
        .data_out    (data_out),
        .word_valid  (word_valid),
        .slip_count  (slip_count)
    );

    logic          stream [0:NBITS-1];
    int            tests = 0;
    int            fails = 0;
    int            n, p, adv, lock_b;
    logic [CW-1:0] slip_b;
    logic          exp_v;
    logic [W-1:0]  exp_d;
    logic          pending;
    string         cur_req;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive bit n and request; advance the bench's own model of R3-R8.
    task automatic drive(input logic req);
        bit acc, adv_edge;
        ser_in   = stream[n];
        slip_req = req;
        acc = req && (n >= p) && (lock_b == 0);
        if (acc) lock_b = 2 * W;
        else if (lock_b > 0) lock_b--;
        adv_edge = (n >= p) && !acc;
        if (adv_edge) adv++;
        exp_v = adv_edge && (adv % W == 0);
        if (exp_v)
            for (int i = 0; i < W; i++) exp_d[W-1-i] = stream[n-W+1+i];
        if (acc) slip_b = (slip_b == CW'(W - 1)) ? '0 : slip_b + 1'b1;
        n++;
        pending = 1'b1;
    endtask

    // One clock: check the previous edge's outputs, then drive the next bit.
    task automatic step(input logic req);
        @(negedge clk);
        if (pending) begin
            check(word_valid == exp_v, cur_req, word_valid, exp_v);
            check(data_out == exp_d, exp_v ? "R1" : "R10", data_out, exp_d);
            check(slip_count == slip_b, "R6", slip_count, slip_b);
        end
        drive(req);
    endtask

    task automatic do_reset(input int deg);
        @(negedge clk);
        rst_n = 1'b0; slip_req = 1'b0; ser_in = 1'b0; pending = 1'b0;
        frame_phase = DEG_W'(deg);
        repeat (3) @(negedge clk);
        check(data_out == '0, "R9", data_out, 0);
        check(word_valid == 1'b0, "R9", word_valid, 0);
        check(slip_count == '0, "R9", slip_count, 0);
        p = (deg / 360) % W; n = 0; adv = 0; lock_b = 0; slip_b = '0; exp_d = '0;
        rst_n = 1'b1;
        drive(1'b0);
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < NBITS; i++) begin
            stream[i] = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        pending = 1'b0;

        // R3 / R4: every phase, with a sub-bit remainder that must not matter.
        cur_req = "R3";
        for (int ph = 0; ph < W; ph++) begin
            do_reset(ph * 360 + (ph * 53) % 360);
            repeat (4 * W + 4) step(1'b0);
        end
        cur_req = "R4";
        do_reset(W * 360 - 1);
        repeat (4 * W + 4) step(1'b0);

        // R5: a single slip stretches one word interval by a bit.
        cur_req = "R5";
        do_reset(3 * 360);
        repeat (20) step(1'b0);
        step(1'b1);
        repeat (3 * W) step(1'b0);

        // R7: a request held high through the lockout is taken again at s+2W+1.
        cur_req = "R7";
        step(1'b1);
        repeat (2 * W + 1) step(1'b1);
        repeat (3 * W) step(1'b0);

        // R9 at the next reset (slip count non-zero), then R6: full wrap.
        cur_req = "R6";
        do_reset(2 * 360);
        repeat (12) step(1'b0);
        for (int k = 0; k < W; k++) begin
            step(1'b1);
            repeat (2 * W + 2) step(1'b0);
        end
        repeat (2 * W) step(1'b0);
        @(negedge clk);
        check(slip_count == '0, "R6", slip_count, 0);
        pending = 1'b0;
        drive(1'b0);

        // R8: a slip during the phase hold is ignored.
        cur_req = "R8";
        do_reset(5 * 360 + 100);
        step(1'b1);
        step(1'b1);
        repeat (3 * W) step(1'b0);
        @(negedge clk);
        check(slip_count == '0, "R8", slip_count, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule